// File: doc/BRIEF.md
# Oscillator-Sampled Entropy Collector

This block turns two groups of free-running oscillator signals into a stream of raw entropy bits and offers the newest bits to software through a small read-only register interface. Each oscillator line is asynchronous to the system clock, so every line first passes through its own two-flop synchronizer. A free-running cycle counter marks one sampling event every `SAMPLE_PERIOD` cycles. At each event, each group's synchronized lines are folded by XOR into one bit. The two group bits from one event and the two from the next event are XORed together into a single entropy bit.

Entropy bits move into a 32-bit word register without pause. Software never freezes that word: a read always returns the latest 32 bits. A ready flag in the status register tells software when a fresh word may be taken. The flag sets only after twice the word width of new bits has been gathered since the previous word read. Consecutive words therefore stay separated by at least one full word of discarded bits. The output is raw entropy, meant to seed a deterministic random bit generator elsewhere.

Top module: `entropy_collector`

## Requirements
- R1: Counting rising edges after reset release from 1, sampling events happen on edges SAMPLE_PERIOD, 2*SAMPLE_PERIOD, 3*SAMPLE_PERIOD and so on. Two events are never closer together than SAMPLE_PERIOD cycles.
- R2: At each event, each group's inputs, after a two-flop synchronizer, are XOR-reduced to one bit. A line must be stable for two cycles before the event edge for its value to count.
- R3: Odd-numbered events after reset (first, third, ...) only store the two group bits. Even-numbered events produce one entropy bit, equal to the XOR of the four group bits from that event pair.
- R4: Each entropy bit enters bit 0 of the 32-bit word and the older bits move one place up. Shifting never waits for software.
- R5: The ready flag, read as bit 0 of the status register at address 0x09, sets once 64 entropy bits have been produced since reset or the last word read. It then stays set, with no wrap, until a word read.
- R6: A read of address 0x20 returns the word and clears the ready flag and the collected-bit count. A read of the status register clears nothing.
- R7: A word read taken before ready has set returns the latest 32 bits, and these may overlap bits returned by the previous word read. The read is neither stalled nor flagged.
- R8: Read data is registered and appears on the cycle after a select with write enable low. Read data is zero on every other cycle, and for unmapped addresses. Status bits 31..1 always read zero.
- R9: A select with write enable high changes no state and returns zero read data.
- R10: A synchronous active-low reset clears the cycle counter, the event phase, the word, the bit count and the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_grp_a | input | GROUP_SIZE | Asynchronous oscillator lines, group A |
| osc_grp_b | input | GROUP_SIZE | Asynchronous oscillator lines, group B |
| cs | input | 1 | Register access select |
| we | input | 1 | Write enable (writes have no effect) |
| addr | input | 8 | Register address |
| rdata | output | 32 | Registered read data |

## Verification
The assertions assume that no word read falls on the same edge as a completed entropy bit. If the two met, the count would restart at one and not at zero. The assertions also assume that reset is held for at least two edges, so the first checked cycle sees defined history. The bench changes the oscillator lines only on the falling edge right after a sampling event, which keeps them steady through the synchronizer delay. It holds every bus access away from the edges where events fall. It runs the block with a short sampling period so that many 64-bit collection rounds fit into one run.

// File: rtl/entc_pkg.sv
package entc_pkg;

  localparam logic [7:0] ADDR_STATUS = 8'h09;
  localparam logic [7:0] ADDR_WORD   = 8'h20;
  localparam int         BUS_W       = 32;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;

  // Four group reductions over an event pair fold into one entropy bit.
  function automatic logic combine_pair(input logic a_first, input logic b_first,
                                        input logic a_second, input logic b_second);
    return a_first ^ b_first ^ a_second ^ b_second;
  endfunction

  // Status register image: ready in bit 0, everything else zero.
  function automatic logic [BUS_W-1:0] status_image(input logic ready);
    return {{(BUS_W-1){1'b0}}, ready};
  endfunction

endpackage

// File: rtl/entc_sync.sv
module entc_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;

endmodule

// File: rtl/entc_group.sv
module entc_group #(
  parameter int GROUP_SIZE = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP_SIZE-1:0] osc,
  input  logic                  capture,
  output logic                  red_now,
  output logic                  red_held
);

  logic [GROUP_SIZE-1:0] osc_sync;
  logic                  held_q;

  entc_sync #(.W(GROUP_SIZE)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(osc),
    .d_sync (osc_sync)
  );

  assign red_now = ^osc_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else if (capture) held_q <= red_now;
  end

  assign red_held = held_q;

endmodule

// File: rtl/entc_sampler.sv
module entc_sampler
  import entc_pkg::*;
#(
  parameter int SAMPLE_PERIOD = 4096
) (
  input  logic   clk,
  input  logic   rst_n,
  output logic   sample_evt,
  output phase_e phase_q
);

  localparam int CW = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign sample_evt = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_FIRST;
    end else begin
      cnt_q <= sample_evt ? '0 : cnt_q + 1'b1;
      if (sample_evt)
        phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end
  end

endmodule

// File: rtl/entc_collector.sv
module entc_collector #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              rd_clear,
  output logic [WORD_W-1:0] word,
  output logic              ready
);

  localparam int READY_BITS = 2 * WORD_W;
  localparam int NW         = $clog2(READY_BITS + 1);
  localparam logic [NW-1:0] FULL = NW'(READY_BITS);

  logic [WORD_W-1:0] word_q;
  logic [NW-1:0]     bits_q;

  function automatic logic [NW-1:0] sat_inc(input logic [NW-1:0] v);
    return (v == FULL) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      bits_q <= '0;
    end else begin
      if (bit_valid) word_q <= {word_q[WORD_W-2:0], bit_val};
      if (rd_clear)       bits_q <= bit_valid ? NW'(1) : '0;
      else if (bit_valid) bits_q <= sat_inc(bits_q);
    end
  end

  assign word  = word_q;
  assign ready = (bits_q == FULL);

endmodule

// File: rtl/entc_regs.sv
module entc_regs
  import entc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [BUS_W-1:0] word,
  input  logic             ready,
  output logic             rd_word,
  output logic [BUS_W-1:0] rdata
);

  logic             rd_any;
  logic [BUS_W-1:0] rdata_q;

  assign rd_any  = cs && !we;
  assign rd_word = rd_any && (addr == ADDR_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_any) begin
      case (addr)
        ADDR_STATUS: rdata_q <= status_image(ready);
        ADDR_WORD:   rdata_q <= word;
        default:     rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import entc_pkg::*;
#(
  parameter int SAMPLE_PERIOD = 4096,
  parameter int GROUP_SIZE    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP_SIZE-1:0] osc_grp_a,
  input  logic [GROUP_SIZE-1:0] osc_grp_b,
  input  logic                  cs,
  input  logic                  we,
  input  logic [7:0]            addr,
  output logic [31:0]           rdata
);

  localparam int NGROUPS = 2;
  localparam int WORD_W  = BUS_W;

  logic [NGROUPS-1:0][GROUP_SIZE-1:0] osc_all;
  logic [NGROUPS-1:0]                 red_now;
  logic [NGROUPS-1:0]                 red_held;

  // Named internal events for the bound checker.
  logic              sample_evt;
  phase_e            phase_q;
  logic              bit_valid;
  logic              bit_val;
  logic [WORD_W-1:0] word;
  logic              ready;
  logic              rd_word;

  assign osc_all[0] = osc_grp_a;
  assign osc_all[1] = osc_grp_b;

  entc_sampler #(.SAMPLE_PERIOD(SAMPLE_PERIOD)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_evt(sample_evt),
    .phase_q   (phase_q)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    entc_group #(.GROUP_SIZE(GROUP_SIZE)) u_group (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc     (osc_all[g]),
      .capture (sample_evt && (phase_q == PH_FIRST)),
      .red_now (red_now[g]),
      .red_held(red_held[g])
    );
  end

  assign bit_valid = sample_evt && (phase_q == PH_SECOND);
  assign bit_val   = combine_pair(red_held[0], red_held[1], red_now[0], red_now[1]);

  entc_collector #(.WORD_W(WORD_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_valid(bit_valid),
    .bit_val  (bit_val),
    .rd_clear (rd_word),
    .word     (word),
    .ready    (ready)
  );

  entc_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .we     (we),
    .addr   (addr),
    .word   (word),
    .ready  (ready),
    .rd_word(rd_word),
    .rdata  (rdata)
  );

endmodule

// File: rtl/entc_checker.sv
module entc_checker #(
  parameter int PERIOD = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_evt,
  input logic        bit_valid,
  input logic        bit_val,
  input logic [31:0] word,
  input logic        ready,
  input logic        rd_word,
  input logic        cs,
  input logic        we,
  input logic [31:0] rdata
);

  logic [31:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= sample_evt ? '0 : gap_q + 1'b1;
  end

  a_r1_event_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt == (gap_q == 32'(PERIOD - 1)));

  a_r3_bit_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> sample_evt);

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !bit_valid) |=> !bit_valid);

  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> (word[0] == $past(bit_val)) && (word[31:1] == $past(word[30:0])));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(word));

  a_r5_rise_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(bit_valid));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(rd_word));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word |=> !ready);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (rdata == 32'h0));

  a_r9_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we) |=> (rdata == 32'h0));

endmodule

bind entropy_collector entc_checker #(.PERIOD(SAMPLE_PERIOD)) u_entc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_evt(sample_evt),
  .bit_valid (bit_valid),
  .bit_val   (bit_val),
  .word      (word),
  .ready     (ready),
  .rd_word   (rd_word),
  .cs        (cs),
  .we        (we),
  .rdata     (rdata)
);

// File: tb/entropy_collector_bench.sv
module entropy_collector_bench;

  localparam int P = 16;
  localparam int G = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [G-1:0]  osc_a = 16'h0001;
  logic [G-1:0]  osc_b = 16'h0000;
  logic          cs = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [31:0]   rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Independent model state, advanced on rising edges from port values.
  int          ecnt = 0;
  int          nevt = 0;
  bit          mphase = 1'b0;
  bit          mfirst = 1'b0;
  logic [31:0] mword = '0;
  int          mcnt = 0;
  int          mtotal = 0;
  bit          evt_flag = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk = ~clk;

  entropy_collector #(.SAMPLE_PERIOD(P), .GROUP_SIZE(G)) u_entropy_collector (
    .clk(clk), .rst_n(rst_n), .osc_grp_a(osc_a), .osc_grp_b(osc_b),
    .cs(cs), .we(we), .addr(addr), .rdata(rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      ecnt = 0; nevt = 0; mphase = 0; mfirst = 0; mword = '0;
      mcnt = 0; evt_flag = 0;
    end else begin
      logic r;
      evt_flag = 0;
      ecnt++;
      if (cs && !we && addr == 8'h20) mcnt = 0;
      if (ecnt % P == 0) begin
        evt_flag = 1;
        nevt++;
        r = (^osc_a) ^ (^osc_b);
        if (!mphase) mfirst = r;
        else begin
          mword = {mword[30:0], mfirst ^ r};
          if (mcnt < 64) mcnt++;
          mtotal++;
        end
        mphase = !mphase;
      end
    end
  end

  always @(negedge clk) begin
    if (evt_flag) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      if (nevt == 1) begin
        osc_a = '0; osc_b = '0;
      end else begin
        osc_a = lfsr[15:0]; osc_b = lfsr[31:16];
      end
      evt_flag = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; skips edges where an event falls.
  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    while ((ecnt + 1) % P == 0) @(negedge clk);
    cs = 1; we = 0; addr = a;
    @(negedge clk);
    d = rdata;
    cs = 0;
  endtask

  task automatic bus_write(input logic [7:0] a, output logic [31:0] d);
    while ((ecnt + 1) % P == 0) @(negedge clk);
    cs = 1; we = 1; addr = a;
    @(negedge clk);
    d = rdata;
    cs = 0; we = 0;
  endtask

  task automatic read_word_checked(input string req, output logic [31:0] d);
    logic [31:0] exp;
    while ((ecnt + 1) % P == 0) @(negedge clk);
    exp = mword;
    bus_read(8'h20, d);
    check(req, d, exp);
  endtask

  task automatic wait_total(input int target);
    while (mtotal < target) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // R10, R1, R3: reset values and timing of the first bit.
  task automatic t_reset_and_first_bit();
    logic [31:0] d;
    bus_read(8'h09, d);
    check("R10 status after reset", d, 32'h0);
    while (ecnt + 1 != 2 * P - 1) @(negedge clk);
    bus_read(8'h20, d);
    check("R1 word before second event", d, 32'h0);
    while (ecnt + 1 != 2 * P + 1) @(negedge clk);
    bus_read(8'h20, d);
    check("R3 first bit after second event", d, 32'h1);
  endtask

  // R5, R2, R4, R6: ready after 64 bits, word content, read clears.
  task automatic t_ready_round(output logic [31:0] got);
    logic [31:0] d;
    wait_total(mtotal + (64 - mcnt) - 1);
    bus_read(8'h09, d);
    check("R5 not ready at 63 bits", d, 32'h0);
    wait_total(mtotal + 1);
    bus_read(8'h09, d);
    check("R5 ready at 64 bits", d, 32'h1);
    bus_read(8'h09, d);
    check("R6 status read keeps ready", d, 32'h1);
    read_word_checked("R2 R4 word content", got);
    bus_read(8'h09, d);
    check("R6 word read clears ready", d, 32'h0);
  endtask

  // R7: an early read returns shifted, overlapping bits.
  task automatic t_early_read(input logic [31:0] prev);
    logic [31:0] d;
    logic [31:0] s;
    int start;
    start = mtotal;
    wait_total(start + 5);
    read_word_checked("R7 early word", d);
    s = prev << 5;
    check("R7 overlap with previous", {d[31:5], 5'b0}, s);
    bus_read(8'h09, d);
    check("R7 early read not ready", d, 32'h0);
  endtask

  // R9, R5, R8: writes, saturation, unmapped addresses.
  task automatic t_writes_and_unmapped();
    logic [31:0] d;
    wait_total(mtotal + 64);
    bus_write(8'h20, d);
    check("R9 write returns zero", d, 32'h0);
    bus_write(8'h09, d);
    check("R9 write to status returns zero", d, 32'h0);
    bus_read(8'h09, d);
    check("R9 ready survives writes", d, 32'h1);
    wait_total(mtotal + 20);
    bus_read(8'h09, d);
    check("R5 ready held past 64 bits", d, 32'h1);
    bus_read(8'h00, d);
    check("R8 unmapped 0x00", d, 32'h0);
    bus_read(8'h21, d);
    check("R8 unmapped 0x21", d, 32'h0);
    bus_read(8'h08, d);
    check("R8 unmapped 0x08", d, 32'h0);
    @(negedge clk);
    check("R8 idle read data zero", rdata, 32'h0);
    read_word_checked("R8 word after unmapped", d);
  endtask

  // R10: reset in the middle clears ready and word.
  task automatic t_mid_reset();
    logic [31:0] d;
    wait_total(mtotal + 64);
    bus_read(8'h09, d);
    check("R10 ready before reset", d, 32'h1);
    do_reset();
    bus_read(8'h09, d);
    check("R10 status after mid reset", d, 32'h0);
    bus_read(8'h20, d);
    check("R10 word after mid reset", d, 32'h0);
  endtask

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_and_first_bit();
    t_ready_round(w);
    t_early_read(w);
    t_ready_round(w);
    t_writes_and_unmapped();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule